// File: doc/BRIEF.md
# Exception Vector and Restart Unit

This unit decides where instruction fetch goes when an exception is taken, and where execution resumes once the handler has finished. For each event it takes the cause code, the PC of the instruction involved and the current privileged-mode flag. It adds a fixed per-cause offset to a programmable 64-bit handler base register to form the new PC. It also updates an exception-address register with the restart point and, when the event arrives outside privileged mode, asks the core to enter that mode.

The same unit carries out the return-from-exception operation. Issued in privileged mode, it sends fetch to the saved exception address. Issued outside privileged mode, it is illegal and is turned into an unimplemented-opcode exception. Software may write the base register and the exception-address register directly.

All outputs are registered. A redirect appears on the clock edge after the request, together with the matching next PC, the updated exception address and the mode requests.

Top module: `exv_unit`

## Requirements
- R1: While `rst` is high, the registered outputs show the reset vector: `redirect_valid`=1, `redirect_pc` = DEF_BASE + 0x0001, `redirect_npc` = that value + 4, `priv_enter`=1, `priv_leave`=0 and `exc_addr`=0. The base register loads DEF_BASE.
- R2: One cycle after `evt_valid`, `redirect_pc` = base + offset(`evt_cause`). The `evt_cause` encodings and their offsets are: 0 reset 0x0001, 1 machine check 0x0401, 2 arithmetic 0x0501, 3 interrupt 0x0101, 4 native data TLB miss 0x0201, 5 privileged data TLB miss 0x0281, 6 alignment 0x0301, 7 data TLB fault 0x0381, 8 data access violation 0x0381, 9 instruction TLB miss 0x0181, 10 instruction TLB fault 0x0181, 11 instruction access violation 0x0081, 12 unimplemented opcode 0x0481, 13 FP disabled 0x0581, 14 privileged call 0x2001.
- R3: Cause 15, integer overflow, behaves exactly like cause 2: the same vector 0x0501 and the same restart rule.
- R4: Causes 2, 14 and 15 are traps, and `exc_addr` becomes `cur_pc` + 4. Every other cause is a fault, and `exc_addr` becomes `cur_pc`.
- R5: An interrupt (cause 3) taken while `in_priv`=1 leaves `exc_addr` unchanged.
- R6: Whenever `redirect_valid` is 1, `redirect_npc` = `redirect_pc` + 4. After reset, `redirect_valid` is 1 only in the cycle after an accepted `evt_valid` or `rfe_valid`, and is 0 otherwise.
- R7: When `rfe_valid` is high with `in_priv`=1, the next cycle shows `redirect_pc` = `exc_addr`, `priv_leave` = NOT `exc_addr[0]`, and `priv_enter`=0.
- R8: When `rfe_valid` is high with `in_priv`=0, it is treated as an unimplemented-opcode fault (offset 0x0481) at `cur_pc`: `exc_addr` becomes `cur_pc` and `priv_enter`=1.
- R9: A write through `exca_wr` stores `exca_wdata` with bit 1 forced to 0. If an exception captures `exc_addr` in the same cycle, the capture wins.
- R10: On any exception, `priv_enter` = NOT `in_priv`, and `priv_leave`=0.
- R11: A write through `base_wr` applies to events from the next cycle on. An event in the same cycle as the write still uses the old base.
- R12: When `evt_valid` and `rfe_valid` are high together, the event is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Exception, trap or interrupt is being taken |
| evt_cause | input | 4 | Cause code (see R2) |
| cur_pc | input | 64 | PC of the instruction that takes the event or issues the return |
| in_priv | input | 1 | Core is currently in privileged mode |
| rfe_valid | input | 1 | Return-from-exception request |
| base_wr | input | 1 | Write enable for the handler base register |
| base_wdata | input | 64 | New handler base value |
| exca_wr | input | 1 | Write enable for the exception-address register |
| exca_wdata | input | 64 | New exception-address value |
| redirect_valid | output | 1 | Fetch redirect is present this cycle |
| redirect_pc | output | 64 | New PC |
| redirect_npc | output | 64 | New PC + 4 |
| exc_addr | output | 64 | Exception-address register |
| priv_enter | output | 1 | Request to enter privileged mode |
| priv_leave | output | 1 | Request to leave privileged mode on return |

## Verification
The assertions assume that `in_priv` is steady during a request and that the handler base keeps bit 0 clear, so that the low bit of every handler PC reads as the privileged marker. The stimulus writes only bases with bit 0 clear. It changes inputs only at the falling edge and keeps every request to a single cycle, so each redirect can be matched to exactly one request. Simultaneous requests are driven only in the scenarios aimed at R9, R11 and R12.

// File: rtl/exv_pkg.sv
package exv_pkg;
  localparam int CAUSE_W = 4;
  localparam int OFS_W   = 14;

  typedef enum logic [CAUSE_W-1:0] {
    C_RESET  = 4'd0,
    C_MCHK   = 4'd1,
    C_ARITH  = 4'd2,
    C_INTR   = 4'd3,
    C_NDTB   = 4'd4,
    C_PDTB   = 4'd5,
    C_ALIGN  = 4'd6,
    C_DFAULT = 4'd7,
    C_DACV   = 4'd8,
    C_IMISS  = 4'd9,
    C_IFAULT = 4'd10,
    C_IACV   = 4'd11,
    C_OPCDEC = 4'd12,
    C_FPOFF  = 4'd13,
    C_PCALL  = 4'd14,
    C_IOVF   = 4'd15
  } cause_e;

  localparam logic [OFS_W-1:0] RESET_OFS = 14'h0001;
endpackage

// File: rtl/exv_vector_table.sv
module exv_vector_table
  import exv_pkg::*;
(
  input  cause_e           cause,
  output logic [OFS_W-1:0] offset,
  output logic             skip_insn
);
  always_comb begin
    skip_insn = 1'b0;
    unique case (cause)
      C_RESET:           offset = RESET_OFS;
      C_MCHK:            offset = 14'h0401;
      C_ARITH, C_IOVF: begin
                         offset    = 14'h0501;
                         skip_insn = 1'b1;
      end
      C_INTR:            offset = 14'h0101;
      C_NDTB:            offset = 14'h0201;
      C_PDTB:            offset = 14'h0281;
      C_ALIGN:           offset = 14'h0301;
      C_DFAULT, C_DACV:  offset = 14'h0381;
      C_IMISS, C_IFAULT: offset = 14'h0181;
      C_IACV:            offset = 14'h0081;
      C_OPCDEC:          offset = 14'h0481;
      C_FPOFF:           offset = 14'h0581;
      C_PCALL: begin
                         offset    = 14'h2001;
                         skip_insn = 1'b1;
      end
      default:           offset = 14'h0481;
    endcase
  end
endmodule

// File: rtl/exv_csr_regs.sv
module exv_csr_regs #(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] DEF_BASE = 64'h0000_0000_0001_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            base_wr,
  input  logic [XLEN-1:0] base_wdata,
  input  logic            cap_en,
  input  logic [XLEN-1:0] cap_val,
  input  logic            sw_wr,
  input  logic [XLEN-1:0] sw_val,
  output logic [XLEN-1:0] base_q,
  output logic [XLEN-1:0] exc_q
);
  localparam logic [XLEN-1:0] BIT1_CLR = ~(XLEN'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= DEF_BASE;
      exc_q  <= '0;
    end else begin
      if (base_wr) base_q <= base_wdata;
      if (cap_en)     exc_q <= cap_val;
      else if (sw_wr) exc_q <= sw_val & BIT1_CLR;
    end
  end

  a_r9_bit1_clear: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && !cap_en) |=> (exc_q[1] == 1'b0));

  a_r11_base_write: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> (base_q == $past(base_wdata)));
endmodule

// File: rtl/exv_redirect_calc.sv
module exv_redirect_calc
  import exv_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic               evt_valid,
  input  logic [CAUSE_W-1:0] evt_cause,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               in_priv,
  input  logic               rfe_valid,
  input  logic [XLEN-1:0]    base_q,
  input  logic [XLEN-1:0]    exc_q,
  output logic               go,
  output logic [XLEN-1:0]    target,
  output logic               cap_en,
  output logic [XLEN-1:0]    cap_val,
  output logic               enter,
  output logic               leave
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  cause_e           eff_cause;
  logic [OFS_W-1:0] offset;
  logic             skip_insn;
  logic             rfe_ok;
  logic             take_exc;

  assign rfe_ok    = rfe_valid && !evt_valid && in_priv;
  assign take_exc  = evt_valid || (rfe_valid && !in_priv);
  assign eff_cause = evt_valid ? cause_e'(evt_cause) : C_OPCDEC;

  exv_vector_table u_table (
    .cause     (eff_cause),
    .offset    (offset),
    .skip_insn (skip_insn)
  );

  always_comb begin
    go      = take_exc || rfe_ok;
    target  = exc_q;
    cap_en  = 1'b0;
    cap_val = cur_pc;
    enter   = 1'b0;
    leave   = 1'b0;
    if (take_exc) begin
      target  = base_q + XLEN'(offset);
      enter   = !in_priv;
      cap_en  = !(eff_cause == C_INTR && in_priv);
      cap_val = skip_insn ? cur_pc + STEP : cur_pc;
    end else if (rfe_ok) begin
      leave = !exc_q[0];
    end
  end
endmodule

// File: rtl/exv_unit.sv
module exv_unit
  import exv_pkg::*;
#(
  parameter int              XLEN       = 64,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] DEF_BASE   = 64'h0000_0000_0001_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid,
  input  logic [CAUSE_W-1:0] evt_cause,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               in_priv,
  input  logic               rfe_valid,
  input  logic               base_wr,
  input  logic [XLEN-1:0]    base_wdata,
  input  logic               exca_wr,
  input  logic [XLEN-1:0]    exca_wdata,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [XLEN-1:0]    redirect_npc,
  output logic [XLEN-1:0]    exc_addr,
  output logic               priv_enter,
  output logic               priv_leave
);
  localparam logic [XLEN-1:0] STEP     = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] RST_PC   = DEF_BASE + XLEN'(RESET_OFS);

  logic [XLEN-1:0] base_q, exc_q, target, cap_val;
  logic            go, cap_en, enter, leave;

  exv_csr_regs #(.XLEN(XLEN), .DEF_BASE(DEF_BASE)) u_csr (
    .clk        (clk),
    .rst        (rst),
    .base_wr    (base_wr),
    .base_wdata (base_wdata),
    .cap_en     (cap_en),
    .cap_val    (cap_val),
    .sw_wr      (exca_wr),
    .sw_val     (exca_wdata),
    .base_q     (base_q),
    .exc_q      (exc_q)
  );

  exv_redirect_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_calc (
    .evt_valid (evt_valid),
    .evt_cause (evt_cause),
    .cur_pc    (cur_pc),
    .in_priv   (in_priv),
    .rfe_valid (rfe_valid),
    .base_q    (base_q),
    .exc_q     (exc_q),
    .go        (go),
    .target    (target),
    .cap_en    (cap_en),
    .cap_val   (cap_val),
    .enter     (enter),
    .leave     (leave)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b1;
      redirect_pc    <= RST_PC;
      redirect_npc   <= RST_PC + STEP;
      priv_enter     <= 1'b1;
      priv_leave     <= 1'b0;
    end else begin
      redirect_valid <= go;
      priv_enter     <= go && enter;
      priv_leave     <= go && leave;
      if (go) begin
        redirect_pc  <= target;
        redirect_npc <= target + STEP;
      end
    end
  end

  assign exc_addr = exc_q;

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid && !rfe_valid) |=> !redirect_valid);

  a_r5_intr_keeps_addr: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_cause == C_INTR && in_priv && !exca_wr) |=> $stable(exc_addr));

  a_r10_enter_req: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !in_priv) |=> (redirect_valid && priv_enter && !priv_leave));

  a_r8_bad_return: assert property (@(posedge clk) disable iff (rst)
    (rfe_valid && !evt_valid && !in_priv) |=>
      (redirect_pc == $past(base_q) + XLEN'(14'h0481) && exc_addr == $past(cur_pc)));

  a_r7_good_return: assert property (@(posedge clk) disable iff (rst)
    (rfe_valid && !evt_valid && in_priv) |=>
      (redirect_pc == $past(exc_addr) && !priv_enter));

  a_r2_priv_marker: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !base_q[0]) |=> redirect_pc[0]);
endmodule

// File: tb/tb_exv_unit.sv
module tb_exv_unit;
  localparam logic [63:0] DEFB = 64'h0000_0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        evt_valid, in_priv, rfe_valid, base_wr, exca_wr;
  logic [3:0]  evt_cause;
  logic [63:0] cur_pc, base_wdata, exca_wdata;
  logic        redirect_valid, priv_enter, priv_leave;
  logic [63:0] redirect_pc, redirect_npc, exc_addr;

  int compared = 0;
  int mismatched = 0;
  logic [63:0] m_base, m_exc;

  always #10 clk = ~clk;

  exv_unit #(.XLEN(64), .INSN_BYTES(4), .DEF_BASE(DEFB)) dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_cause(evt_cause),
    .cur_pc(cur_pc), .in_priv(in_priv), .rfe_valid(rfe_valid),
    .base_wr(base_wr), .base_wdata(base_wdata), .exca_wr(exca_wr),
    .exca_wdata(exca_wdata), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .redirect_npc(redirect_npc),
    .exc_addr(exc_addr), .priv_enter(priv_enter), .priv_leave(priv_leave)
  );

  function automatic logic [63:0] ofs(input int c);
    case (c)
      0: return 64'h0001;   1: return 64'h0401;  2: return 64'h0501;
      3: return 64'h0101;   4: return 64'h0201;  5: return 64'h0281;
      6: return 64'h0301;   7: return 64'h0381;  8: return 64'h0381;
      9: return 64'h0181;  10: return 64'h0181; 11: return 64'h0081;
      12: return 64'h0481; 13: return 64'h0581; 14: return 64'h2001;
      default: return 64'h0501;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_valid = 0; rfe_valid = 0; base_wr = 0; exca_wr = 0;
    evt_cause = 0; in_priv = 0; cur_pc = 0; base_wdata = 0; exca_wdata = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 valid", 64'(redirect_valid), 1);
    chk("R1 pc", redirect_pc, DEFB + 1);
    chk("R1 npc", redirect_npc, DEFB + 5);
    chk("R1 enter", 64'(priv_enter), 1);
    chk("R1 exc", exc_addr, 0);
    rst = 0;
    m_base = DEFB; m_exc = 0;
    @(negedge clk);
    chk("R6 idle after reset", 64'(redirect_valid), 0);
  endtask

  task automatic t_all_causes();
    for (int c = 0; c < 16; c++) begin
      logic [63:0] pc;
      pc = 64'h4000_0000 + 64'(c * 64);
      evt_valid = 1; evt_cause = 4'(c); cur_pc = pc; in_priv = 0;
      @(negedge clk);
      idle_inputs();
      m_exc = (c == 2 || c == 14 || c == 15) ? pc + 4 : pc;
      chk(c == 15 ? "R3 vector" : "R2 vector", redirect_pc, m_base + ofs(c));
      chk("R6 npc", redirect_npc, m_base + ofs(c) + 4);
      chk("R4 exc_addr", exc_addr, m_exc);
      chk("R10 enter", 64'(priv_enter), 1);
      chk("R6 valid", 64'(redirect_valid), 1);
    end
    @(negedge clk);
    chk("R6 drop", 64'(redirect_valid), 0);
  endtask

  task automatic t_intr_priv();
    evt_valid = 1; evt_cause = 3; cur_pc = 64'h7777_0000; in_priv = 1;
    @(negedge clk);
    idle_inputs();
    chk("R5 exc kept", exc_addr, m_exc);
    chk("R2 intr vector", redirect_pc, m_base + 64'h0101);
    chk("R10 no enter", 64'(priv_enter), 0);
  endtask

  task automatic t_base_write();
    base_wr = 1; base_wdata = 64'h0000_0008_0000_0000;
    evt_valid = 1; evt_cause = 1; cur_pc = 64'h100; in_priv = 1;
    @(negedge clk);
    idle_inputs();
    chk("R11 old base", redirect_pc, m_base + 64'h0401);
    m_exc = 64'h100;
    m_base = 64'h0000_0008_0000_0000;
    evt_valid = 1; evt_cause = 14; cur_pc = 64'h200; in_priv = 0;
    @(negedge clk);
    idle_inputs();
    m_exc = 64'h204;
    chk("R11 new base", redirect_pc, m_base + 64'h2001);
    chk("R4 pcall skip", exc_addr, m_exc);
  endtask

  task automatic t_exca_write();
    exca_wr = 1; exca_wdata = 64'hFFFF_0000_0000_0007;
    @(negedge clk);
    idle_inputs();
    m_exc = 64'hFFFF_0000_0000_0005;
    chk("R9 mask bit1", exc_addr, m_exc);
    exca_wr = 1; exca_wdata = 64'h1234;
    evt_valid = 1; evt_cause = 6; cur_pc = 64'h9000;
    @(negedge clk);
    idle_inputs();
    m_exc = 64'h9000;
    chk("R9 capture wins", exc_addr, m_exc);
  endtask

  task automatic t_return();
    exca_wr = 1; exca_wdata = 64'h0000_0000_00AB_CD00;
    @(negedge clk);
    idle_inputs();
    m_exc = 64'hABCD00;
    rfe_valid = 1; in_priv = 1; cur_pc = 64'h3000;
    @(negedge clk);
    idle_inputs();
    chk("R7 pc", redirect_pc, m_exc);
    chk("R7 leave", 64'(priv_leave), 1);
    chk("R7 no enter", 64'(priv_enter), 0);
    exca_wr = 1; exca_wdata = 64'h0000_0000_00AB_CD01;
    @(negedge clk);
    idle_inputs();
    m_exc = 64'hABCD01;
    rfe_valid = 1; in_priv = 1;
    @(negedge clk);
    idle_inputs();
    chk("R7 stay priv", 64'(priv_leave), 0);
    chk("R7 pc odd", redirect_pc, m_exc);
    rfe_valid = 1; in_priv = 0; cur_pc = 64'h5550;
    @(negedge clk);
    idle_inputs();
    m_exc = 64'h5550;
    chk("R8 vector", redirect_pc, m_base + 64'h0481);
    chk("R8 exc", exc_addr, m_exc);
    chk("R8 enter", 64'(priv_enter), 1);
  endtask

  task automatic t_priority();
    rfe_valid = 1; evt_valid = 1; evt_cause = 9; in_priv = 1; cur_pc = 64'h6600;
    @(negedge clk);
    idle_inputs();
    m_exc = 64'h6600;
    chk("R12 event wins pc", redirect_pc, m_base + 64'h0181);
    chk("R12 exc", exc_addr, m_exc);
    chk("R12 no leave", 64'(priv_leave), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_all_causes();
        t_intr_priv();
        t_base_write();
        t_exca_write();
        t_return();
        t_priority();
      end
      begin
        repeat (5000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule